// File: doc/BRIEF.md
# Stepped Attenuator Tap Decoder

This block turns level codes for an audio signal path into one-hot tap selects for resistor-ladder attenuators. Each of the two channels has its own 7-bit volume code. The code is split into a coarse select on a ladder with 5 dB steps and a fine select on a ladder with 1 dB steps, so codes 0 to 79 cover 0 dB to -79 dB in 1 dB steps. Any higher code opens both ladders and raises that channel's mute flag. Because the channels are set independently, balance needs no separate control. A loudness flag tells the analog side when a channel sits at or below the -20 dB tap.

A single 4-bit fader code attenuates either the front outputs or the rear outputs. The same setting applies to left and right. Steps are 2 dB down to -20 dB, then 5 dB, and the last code is infinite attenuation. Bass and treble each take a 4-bit code that selects one of 15 boost/cut taps in 2 dB steps, with the middle tap flat.

All decoded selects are captured into one register bank in the cycle where `load` is high. The whole analog setting therefore switches in a single clock edge and never passes through a mixed state.

Top module: `atten_tap_decoder`

## Requirements
- R1: For a volume code v in 0..79, the cycle after `load` shows coarse bit floor(v/5) set (16-bit vector), fine bit v mod 5 set (5-bit vector), and no other bit of either vector set.
- R2: A volume code of 80..127 clears both the coarse and fine vectors of that channel and sets its mute flag. A code below 80 leaves mute low.
- R3: The left and right channel decodes depend only on their own volume code.
- R4: A channel's loudness flag is high exactly when its captured volume code is 20 or greater, mute codes included.
- R5: The fader code f (0..15) sets bit f of the selected side's 16-bit tap vector and no other bit. Codes 0..10 mean 0 to -20 dB in 2 dB steps, 11..14 mean -25 to -40 dB in 5 dB steps, and 15 means infinite attenuation. Side select 0 chooses front and 1 chooses rear.
- R6: The side that is not selected holds bit 0 (0 dB) only.
- R7: A bass or treble code t in 0..14 sets bit t of its 15-bit tap vector only. Bit 7 is flat, lower bits cut and higher bits boost. Code 15 is clamped to bit 7.
- R8: All outputs change only on a clock edge where `load` is high. While `load` is low they hold, whatever the code inputs do.
- R9: After reset, both channels are muted with empty ladders and loudness high, both fader sides select bit 15 (infinite), and bass and treble select bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture all codes on this edge |
| vol_l | input | 7 | Left volume code |
| vol_r | input | 7 | Right volume code |
| fade_code | input | 4 | Fader level code |
| fade_side | input | 1 | 0 attenuates front, 1 attenuates rear |
| bass_code | input | 4 | Bass level code |
| treble_code | input | 4 | Treble level code |
| coarse_l | output | 16 | Left 5 dB ladder tap select |
| fine_l | output | 5 | Left 1 dB ladder tap select |
| coarse_r | output | 16 | Right 5 dB ladder tap select |
| fine_r | output | 5 | Right 1 dB ladder tap select |
| mute_l | output | 1 | Left infinite attenuation |
| mute_r | output | 1 | Right infinite attenuation |
| loud_l | output | 1 | Left at or below loudness tap |
| loud_r | output | 1 | Right at or below loudness tap |
| front_tap | output | 16 | Front fader tap select |
| rear_tap | output | 16 | Rear fader tap select |
| bass_tap | output | 15 | Bass network tap select |
| treble_tap | output | 15 | Treble network tap select |

## Verification
The assertions check the structural properties on every cycle. Each ladder vector is one-hot or, when muted, empty. Fader and tone vectors are always one-hot. Outputs hold while `load` is low, the unselected fader side sits at 0 dB, and mute and loudness follow the captured code. Only the bench's sweeps show that each particular code lands on the right tap index: the divide and modulo split of every volume code, the clamp of tone code 15, and the independence of left from right under opposite code patterns.

// File: rtl/atten_pkg.sv
package atten_pkg;
    localparam int VOL_W     = 7;
    localparam int COARSE_N  = 16;
    localparam int FINE_N    = 5;
    localparam int FADE_N    = 16;
    localparam int TONE_N    = 15;
    localparam int LOUD_CODE = 20;
    localparam int TONE_FLAT = (TONE_N - 1) / 2;
    localparam int FADE_W    = $clog2(FADE_N);
    localparam int TONE_W    = $clog2(TONE_N + 1);
    localparam int NCH       = 2;

    typedef struct packed {
        logic [COARSE_N-1:0] coarse;
        logic [FINE_N-1:0]   fine;
        logic                mute;
        logic                loud;
    } ch_taps_t;

    typedef struct packed {
        ch_taps_t [NCH-1:0]  ch;
        logic [FADE_N-1:0]   front;
        logic [FADE_N-1:0]   rear;
        logic [TONE_N-1:0]   bass;
        logic [TONE_N-1:0]   treble;
    } tap_state_t;
endpackage

// File: rtl/vol_split_dec.sv
module vol_split_dec #(
    parameter int VOL_W     = 7,
    parameter int COARSE_N  = 16,
    parameter int FINE_N    = 5,
    parameter int LOUD_CODE = 20
) (
    input  logic [VOL_W-1:0]    code,
    output logic [COARSE_N-1:0] coarse,
    output logic [FINE_N-1:0]   fine,
    output logic                mute,
    output logic                loud
);
    localparam int STEPS = COARSE_N * FINE_N;

    int unsigned code_i;
    int unsigned coarse_idx;
    int unsigned fine_idx;
    logic        in_range;

    assign code_i     = 32'(code);
    assign in_range   = code_i < STEPS;
    assign coarse_idx = code_i / FINE_N;
    assign fine_idx   = code_i % FINE_N;
    assign mute       = !in_range;
    assign loud       = code_i >= LOUD_CODE;

    for (genvar i = 0; i < COARSE_N; i++) begin : g_coarse
        assign coarse[i] = in_range && (coarse_idx == i);
    end
    for (genvar j = 0; j < FINE_N; j++) begin : g_fine
        assign fine[j] = in_range && (fine_idx == j);
    end
endmodule

// File: rtl/fade_side_dec.sv
module fade_side_dec #(
    parameter int FADE_N = 16,
    parameter int FADE_W = 4
) (
    input  logic [FADE_W-1:0] code,
    input  logic              side,
    output logic [FADE_N-1:0] front,
    output logic [FADE_N-1:0] rear
);
    localparam logic [FADE_N-1:0] ZERO_DB = FADE_N'(1);

    logic [FADE_N-1:0] sel;

    for (genvar i = 0; i < FADE_N; i++) begin : g_sel
        assign sel[i] = (32'(code) == i);
    end

    always_comb begin
        front = side ? ZERO_DB : sel;
        rear  = side ? sel : ZERO_DB;
    end
endmodule

// File: rtl/tone_tap_dec.sv
module tone_tap_dec #(
    parameter int TONE_N    = 15,
    parameter int TONE_W    = 4,
    parameter int TONE_FLAT = 7
) (
    input  logic [TONE_W-1:0] code,
    output logic [TONE_N-1:0] tap
);
    int unsigned idx;

    assign idx = (32'(code) < TONE_N) ? 32'(code) : TONE_FLAT;

    for (genvar i = 0; i < TONE_N; i++) begin : g_tap
        assign tap[i] = (idx == i);
    end
endmodule

// File: rtl/atten_tap_decoder.sv
module atten_tap_decoder
    import atten_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [VOL_W-1:0]    vol_l,
    input  logic [VOL_W-1:0]    vol_r,
    input  logic [FADE_W-1:0]   fade_code,
    input  logic                fade_side,
    input  logic [TONE_W-1:0]   bass_code,
    input  logic [TONE_W-1:0]   treble_code,
    output logic [COARSE_N-1:0] coarse_l,
    output logic [FINE_N-1:0]   fine_l,
    output logic [COARSE_N-1:0] coarse_r,
    output logic [FINE_N-1:0]   fine_r,
    output logic                mute_l,
    output logic                mute_r,
    output logic                loud_l,
    output logic                loud_r,
    output logic [FADE_N-1:0]   front_tap,
    output logic [FADE_N-1:0]   rear_tap,
    output logic [TONE_N-1:0]   bass_tap,
    output logic [TONE_N-1:0]   treble_tap
);
    localparam logic [FADE_N-1:0] FADE_OFF  = FADE_N'(1) << (FADE_N - 1);
    localparam logic [TONE_N-1:0] TONE_MID  = TONE_N'(1) << TONE_FLAT;

    tap_state_t            state_d, state_q, decoded;
    logic [VOL_W-1:0]      vol_code [NCH];

    assign vol_code[0] = vol_l;
    assign vol_code[1] = vol_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        vol_split_dec #(
            .VOL_W    (VOL_W),
            .COARSE_N (COARSE_N),
            .FINE_N   (FINE_N),
            .LOUD_CODE(LOUD_CODE)
        ) u_vol (
            .code  (vol_code[c]),
            .coarse(decoded.ch[c].coarse),
            .fine  (decoded.ch[c].fine),
            .mute  (decoded.ch[c].mute),
            .loud  (decoded.ch[c].loud)
        );
    end

    fade_side_dec #(
        .FADE_N(FADE_N),
        .FADE_W(FADE_W)
    ) u_fade (
        .code (fade_code),
        .side (fade_side),
        .front(decoded.front),
        .rear (decoded.rear)
    );

    tone_tap_dec #(
        .TONE_N   (TONE_N),
        .TONE_W   (TONE_W),
        .TONE_FLAT(TONE_FLAT)
    ) u_bass (
        .code(bass_code),
        .tap (decoded.bass)
    );

    tone_tap_dec #(
        .TONE_N   (TONE_N),
        .TONE_W   (TONE_W),
        .TONE_FLAT(TONE_FLAT)
    ) u_treble (
        .code(treble_code),
        .tap (decoded.treble)
    );

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = decoded;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                state_q.ch[c].coarse <= '0;
                state_q.ch[c].fine   <= '0;
                state_q.ch[c].mute   <= 1'b1;
                state_q.ch[c].loud   <= 1'b1;
            end
            state_q.front  <= FADE_OFF;
            state_q.rear   <= FADE_OFF;
            state_q.bass   <= TONE_MID;
            state_q.treble <= TONE_MID;
        end else begin
            state_q <= state_d;
        end
    end

    assign coarse_l   = state_q.ch[0].coarse;
    assign fine_l     = state_q.ch[0].fine;
    assign mute_l     = state_q.ch[0].mute;
    assign loud_l     = state_q.ch[0].loud;
    assign coarse_r   = state_q.ch[1].coarse;
    assign fine_r     = state_q.ch[1].fine;
    assign mute_r     = state_q.ch[1].mute;
    assign loud_r     = state_q.ch[1].loud;
    assign front_tap  = state_q.front;
    assign rear_tap   = state_q.rear;
    assign bass_tap   = state_q.bass;
    assign treble_tap = state_q.treble;
endmodule

// File: rtl/atten_tap_decoder_chk.sv
module atten_tap_decoder_chk
    import atten_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                load,
    input logic [VOL_W-1:0]    vol_l,
    input logic [VOL_W-1:0]    vol_r,
    input logic                fade_side,
    input logic [COARSE_N-1:0] coarse_l,
    input logic [FINE_N-1:0]   fine_l,
    input logic [COARSE_N-1:0] coarse_r,
    input logic [FINE_N-1:0]   fine_r,
    input logic                mute_l,
    input logic                mute_r,
    input logic                loud_l,
    input logic                loud_r,
    input logic [FADE_N-1:0]   front_tap,
    input logic [FADE_N-1:0]   rear_tap,
    input logic [TONE_N-1:0]   bass_tap,
    input logic [TONE_N-1:0]   treble_tap
);
    localparam int STEPS = COARSE_N * FINE_N;

    // R1
    left_ladder_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_l |-> ($countones(coarse_l) == 1 && $countones(fine_l) == 1));

    // R1
    right_ladder_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_r |-> ($countones(coarse_r) == 1 && $countones(fine_r) == 1));

    // R2
    left_mute_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_l |-> (coarse_l == '0 && fine_l == '0));

    // R2
    right_mute_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_r |-> (coarse_r == '0 && fine_r == '0));

    // R2
    mute_follows_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mute_l == (32'($past(vol_l)) >= STEPS)) && (mute_r == (32'($past(vol_r)) >= STEPS)));

    // R4
    loud_follows_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (loud_l == (32'($past(vol_l)) >= LOUD_CODE)) && (loud_r == (32'($past(vol_r)) >= LOUD_CODE)));

    // R5
    fade_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(front_tap) && $onehot(rear_tap));

    // R6
    fade_other_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ($past(fade_side) ? front_tap[0] : rear_tap[0]));

    // R7
    tone_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(bass_tap) && $onehot(treble_tap));

    // R8
    hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({coarse_l, fine_l, coarse_r, fine_r, mute_l, mute_r, loud_l, loud_r,
                           front_tap, rear_tap, bass_tap, treble_tap}));
endmodule

bind atten_tap_decoder atten_tap_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .vol_l     (vol_l),
    .vol_r     (vol_r),
    .fade_side (fade_side),
    .coarse_l  (coarse_l),
    .fine_l    (fine_l),
    .coarse_r  (coarse_r),
    .fine_r    (fine_r),
    .mute_l    (mute_l),
    .mute_r    (mute_r),
    .loud_l    (loud_l),
    .loud_r    (loud_r),
    .front_tap (front_tap),
    .rear_tap  (rear_tap),
    .bass_tap  (bass_tap),
    .treble_tap(treble_tap)
);

// File: tb/atten_tap_decoder_tb.sv
module atten_tap_decoder_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [6:0]  vol_l = '0, vol_r = '0;
    logic [3:0]  fade_code = '0;
    logic        fade_side = 1'b0;
    logic [3:0]  bass_code = '0, treble_code = '0;
    logic [15:0] coarse_l, coarse_r, front_tap, rear_tap;
    logic [4:0]  fine_l, fine_r;
    logic        mute_l, mute_r, loud_l, loud_r;
    logic [14:0] bass_tap, treble_tap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    atten_tap_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .load(load),
        .vol_l(vol_l), .vol_r(vol_r),
        .fade_code(fade_code), .fade_side(fade_side),
        .bass_code(bass_code), .treble_code(treble_code),
        .coarse_l(coarse_l), .fine_l(fine_l), .coarse_r(coarse_r), .fine_r(fine_r),
        .mute_l(mute_l), .mute_r(mute_r), .loud_l(loud_l), .loud_r(loud_r),
        .front_tap(front_tap), .rear_tap(rear_tap),
        .bass_tap(bass_tap), .treble_tap(treble_tap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    function automatic logic [15:0] exp_coarse(input int v);
        return (v < 80) ? (16'h1 << (v / 5)) : 16'h0;
    endfunction

    function automatic logic [4:0] exp_fine(input int v);
        return (v < 80) ? (5'h1 << (v % 5)) : 5'h0;
    endfunction

    task automatic check_vol(input int vl, input int vr);
        check("R1 coarse_l", 32'(coarse_l), 32'(exp_coarse(vl)));
        check("R1 fine_l", 32'(fine_l), 32'(exp_fine(vl)));
        check("R3 coarse_r", 32'(coarse_r), 32'(exp_coarse(vr)));
        check("R3 fine_r", 32'(fine_r), 32'(exp_fine(vr)));
        check("R2 mute_l", 32'(mute_l), 32'(vl >= 80));
        check("R2 mute_r", 32'(mute_r), 32'(vr >= 80));
        check("R4 loud_l", 32'(loud_l), 32'(vl >= 20));
        check("R4 loud_r", 32'(loud_r), 32'(vr >= 20));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 coarse_l", 32'(coarse_l), 32'h0);
        check("R9 fine_r", 32'(fine_r), 32'h0);
        check("R9 mute", 32'({mute_l, mute_r}), 32'h3);
        check("R9 loud", 32'({loud_l, loud_r}), 32'h3);
        check("R9 front", 32'(front_tap), 32'h8000);
        check("R9 rear", 32'(rear_tap), 32'h8000);
        check("R9 bass", 32'(bass_tap), 32'h0080);
        check("R9 treble", 32'(treble_tap), 32'h0080);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: full volume sweep, right runs opposite to left
        for (int v = 0; v < 128; v++) begin
            vol_l = 7'(v);
            vol_r = 7'(127 - v);
            strobe();
            check_vol(v, 127 - v);
        end

        // R5 R6: every fader code on both sides
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 16; f++) begin
                fade_code = 4'(f);
                fade_side = s[0];
                strobe();
                check("R5 selected side", 32'(s ? rear_tap : front_tap), 32'h1 << f);
                check("R6 other side", 32'(s ? front_tap : rear_tap), 32'h1);
            end
        end

        // R7: every tone code, treble opposite to bass
        for (int t = 0; t < 16; t++) begin
            bass_code = 4'(t);
            treble_code = 4'(15 - t);
            strobe();
            check("R7 bass", 32'(bass_tap), 32'h1 << ((t < 15) ? t : 7));
            check("R7 treble", 32'(treble_tap), 32'h1 << (((15 - t) < 15) ? (15 - t) : 7));
        end

        // R8: change every code without load, outputs must hold
        vol_l = 7'd33; vol_r = 7'd2; fade_code = 4'd4; fade_side = 1'b0;
        bass_code = 4'd3; treble_code = 4'd12;
        strobe();
        check_vol(33, 2);
        vol_l = 7'd90; vol_r = 7'd61; fade_code = 4'd13; fade_side = 1'b1;
        bass_code = 4'd10; treble_code = 4'd1;
        repeat (4) @(negedge clk);
        check("R8 coarse_l held", 32'(coarse_l), 32'(exp_coarse(33)));
        check("R8 mute_l held", 32'(mute_l), 32'h0);
        check("R8 fine_r held", 32'(fine_r), 32'(exp_fine(2)));
        check("R8 front held", 32'(front_tap), 32'h1 << 4);
        check("R8 rear held", 32'(rear_tap), 32'h1);
        check("R8 bass held", 32'(bass_tap), 32'h1 << 3);
        check("R8 treble held", 32'(treble_tap), 32'h1 << 12);
        strobe();
        check_vol(90, 61);
        check("R5 after load", 32'(rear_tap), 32'h1 << 13);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule